// File: doc/BRIEF.md
# SPI Serial EEPROM Slave

This block is the device side of a small serial memory reached over a four-wire SPI link in mode 0: the serial clock idles low, input bits are taken on its rising edge and output bits change on its falling edge. The storage is 256 bytes, held in an internal register array that is cleared by reset. A host selects the device by pulling chip select low. It then sends an opcode byte, followed by an address byte and data where the opcode needs them, most significant bit first.

The block supports four opcodes. Read data (03h) streams bytes from any start address and wraps at the top of the array. Write enable (06h) arms the write enable latch. Byte write (02h) stores one byte. Read status (05h) returns the status byte repeatedly. A byte write takes effect only when chip select rises right after the eighth data bit, and only if the write enable latch is set. That deselect starts a self-timed write cycle. While the cycle runs, memory reads are refused, status polling still works, and the write-in-progress flag is set. When the cycle ends, the write enable latch clears. The serial pins are synchronised into the system clock, and edges of the serial clock are detected there. The serial data output has a separate enable pin that drives the pad tri-state.

Top module: `spi_eeprom_slave`

## Requirements
- R1: After reset, miso_oe_o is 0 and a read status transaction returns 00h.
- R2: Input bits are taken on serial clock rising edges, most significant bit first. Output bits change on falling edges, so the first bit a host samples on a rising edge is bit 7.
- R3: Opcode 03h followed by an address byte returns the byte stored at that address. The first data bit is driven on the falling edge that follows the last address bit.
- R4: During a read, the address advances by one after each byte. Address FFh is followed by 00h, and the read continues for as long as clocks arrive.
- R5: miso_oe_o is 0 whenever chip select is high. Raising chip select at any bit position ends a read.
- R6: A frame holding only opcode 06h sets the write enable latch, status bit 1, when chip select rises.
- R7: Opcode 02h, an address and one data byte, with chip select rising right after the eighth data bit, store the data byte at that address and start the write cycle.
- R8: A write frame that has a rising serial clock edge after the eighth data bit is cancelled. Memory is unchanged, no write cycle starts and the write enable latch keeps its value.
- R9: A write frame sent while the write enable latch is clear is ignored, and memory is unchanged.
- R10: Status bit 0 (write in progress) stays 1 for exactly WRITE_CYCLES system clocks after a write starts. When it falls, the write enable latch is 0.
- R11: While a write cycle runs, opcode 03h is refused and miso_oe_o stays 0 for the rest of that frame. Opcode 05h still returns the status byte.
- R12: The status byte is bit 0 = write in progress, bit 1 = write enable latch, bit 2 = BP_INIT[0], bit 3 = BP_INIT[1], and bits 7..4 = 0. The byte is reloaded with current values every 8 bits for as long as the read status frame continues.
- R13: Any opcode other than 02h, 03h, 05h or 06h is ignored until the next deselect. miso_oe_o stays 0 and the status byte is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, several times faster than the serial clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Chip select, active low |
| sck_i | input | 1 | Serial clock, idles low |
| mosi_i | input | 1 | Serial data from the host |
| miso_o | output | 1 | Serial data to the host |
| miso_oe_o | output | 1 | Output enable for the miso_o pad; 0 means high impedance |

## Verification
The assertions assume a mode 0 host. Each serial clock half-period and each deselect gap must last well over the synchroniser depth plus the edge detector, so no edge is lost or merged. The deselect assertion also counts on the default two synchroniser stages. The bench holds every serial clock half-period at four system clocks and every deselect gap at eight. It changes the data input only while the serial clock is low, well before the next rising edge.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WREN  = 8'h06;

  typedef enum logic [3:0] {
    S_IDLE,
    S_CMD,
    S_ADDR,
    S_WDATA,
    S_WDONE,
    S_RDATA,
    S_RSR,
    S_WREN,
    S_IGNORE
  } state_e;
endpackage

// File: rtl/spi_ee_sync.sv
// Multi-stage synchroniser, STAGES >= 2
module spi_ee_sync #(
  parameter int              WIDTH   = 3,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  localparam int TOT_W = STAGES * WIDTH;

  logic [TOT_W-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= {STAGES{RST_VAL}};
    else         pipe_q <= {pipe_q[TOT_W-WIDTH-1:0], d_i};
  end

  assign q_o = pipe_q[TOT_W-1 -: WIDTH];
endmodule

// File: rtl/spi_ee_edge.sv
module spi_ee_edge #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic rise_o,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= RST_VAL;
    else         prev_q <= sig_i;
  end

  assign rise_o = sig_i & ~prev_q;
  assign fall_o = ~sig_i & prev_q;
endmodule

// File: rtl/spi_ee_wtimer.sv
module spi_ee_wtimer #(
  parameter int CYCLES = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int CNT_W = $clog2(CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= CNT_W'(CYCLES - 1);
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == '0);
endmodule

// File: rtl/spi_ee_mem.sv
module spi_ee_mem #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/spi_ee_ctrl.sv
module spi_ee_ctrl
  import spi_ee_pkg::*;
#(
  parameter int         ADDR_W  = 8,
  parameter logic [1:0] BP_INIT = 2'b00
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_q_i,
  input  logic              cs_rise_i,
  input  logic              cs_fall_i,
  input  logic              sck_rise_i,
  input  logic              sck_fall_i,
  input  logic              mosi_i,
  input  logic              wip_i,
  input  logic              wdone_i,
  input  logic [7:0]        mem_rdata_i,
  output logic [ADDR_W-1:0] mem_raddr_o,
  output logic              wr_start_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic              wel_o,
  output logic              rd_mem_o,
  output logic              miso_o,
  output logic              miso_oe_o
);
  state_e            state_q;
  logic [2:0]        bit_cnt_q;
  logic [2:0]        out_cnt_q;
  logic [7:0]        sh_q;
  logic [7:0]        tx_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        data_q;
  logic              rd_q;
  logic              wel_q;
  logic              miso_q;

  logic [7:0] new_byte;
  logic       byte_done;
  logic [7:0] status;

  assign new_byte  = {sh_q[6:0], mosi_i};
  assign byte_done = sck_rise_i && (bit_cnt_q == 3'd7);
  assign status    = {4'b0000, BP_INIT[1], BP_INIT[0], wel_q, wip_i};

  // next read address: first byte of a burst comes straight from the shifter
  assign mem_raddr_o = (state_q == S_ADDR) ? new_byte[ADDR_W-1:0]
                                           : addr_q + ADDR_W'(1);

  assign wr_start_o = cs_rise_i && (state_q == S_WDONE) && wel_q && !wip_i;
  assign wr_addr_o  = addr_q;
  assign wr_data_o  = data_q;
  assign wel_o      = wel_q;
  assign rd_mem_o   = (state_q == S_RDATA);
  assign miso_o     = miso_q;
  assign miso_oe_o  = (state_q == S_RDATA) || (state_q == S_RSR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      bit_cnt_q <= '0;
      out_cnt_q <= '0;
      sh_q      <= '0;
      tx_q      <= '0;
      addr_q    <= '0;
      data_q    <= '0;
      rd_q      <= 1'b0;
      wel_q     <= 1'b0;
      miso_q    <= 1'b0;
    end else begin
      if (wdone_i) wel_q <= 1'b0;

      if (cs_rise_i) begin
        if (state_q == S_WREN && !wip_i) wel_q <= 1'b1;
        state_q <= S_IDLE;
      end else if (cs_q_i) begin
        state_q <= S_IDLE;
      end else if (cs_fall_i) begin
        state_q   <= S_CMD;
        bit_cnt_q <= '0;
      end else begin
        if (sck_rise_i) begin
          unique case (state_q)
            S_CMD, S_ADDR, S_WDATA: begin
              sh_q      <= new_byte;
              bit_cnt_q <= bit_cnt_q + 3'd1;
              if (byte_done) begin
                if (state_q == S_CMD) begin
                  unique case (new_byte)
                    OP_WREN:  state_q <= wip_i ? S_IGNORE : S_WREN;
                    OP_RDSR: begin
                      state_q   <= S_RSR;
                      tx_q      <= status;
                      out_cnt_q <= '0;
                    end
                    OP_READ: begin
                      state_q <= wip_i ? S_IGNORE : S_ADDR;
                      rd_q    <= 1'b1;
                    end
                    OP_WRITE: begin
                      state_q <= (wip_i || !wel_q) ? S_IGNORE : S_ADDR;
                      rd_q    <= 1'b0;
                    end
                    default:  state_q <= S_IGNORE;
                  endcase
                end else if (state_q == S_ADDR) begin
                  addr_q <= new_byte[ADDR_W-1:0];
                  if (rd_q) begin
                    state_q   <= S_RDATA;
                    tx_q      <= mem_rdata_i;
                    out_cnt_q <= '0;
                  end else begin
                    state_q <= S_WDATA;
                  end
                end else begin
                  data_q  <= new_byte;
                  state_q <= S_WDONE;
                end
              end
            end
            // any further clock after the data byte cancels the write
            S_WDONE: state_q <= S_IGNORE;
            default: ;
          endcase
        end

        if (sck_fall_i && (state_q == S_RDATA || state_q == S_RSR)) begin
          miso_q    <= tx_q[7];
          out_cnt_q <= out_cnt_q + 3'd1;
          if (out_cnt_q == 3'd7) begin
            if (state_q == S_RDATA) begin
              addr_q <= addr_q + ADDR_W'(1);
              tx_q   <= mem_rdata_i;
            end else begin
              tx_q <= status;
            end
          end else begin
            tx_q <= {tx_q[6:0], 1'b0};
          end
        end
      end
    end
  end
endmodule

// File: rtl/spi_eeprom_slave.sv
module spi_eeprom_slave #(
  parameter int         ADDR_W       = 8,
  parameter int         WRITE_CYCLES = 64,
  parameter int         SYNC_STAGES  = 2,
  parameter logic [1:0] BP_INIT      = 2'b00
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sck_i,
  input  logic mosi_i,
  output logic miso_o,
  output logic miso_oe_o
);
  logic [2:0]        pins_q;
  logic              cs_q, sck_q, mosi_q;
  logic              cs_rise, cs_fall, sck_rise, sck_fall;
  logic              wip, wdone, wel, rd_mem, wr_start;
  logic [ADDR_W-1:0] raddr, waddr;
  logic [7:0]        rdata, wdata;

  spi_ee_sync #(
    .WIDTH  (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b001)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({mosi_i, sck_i, cs_ni}),
    .q_o   (pins_q)
  );

  assign cs_q   = pins_q[0];
  assign sck_q  = pins_q[1];
  assign mosi_q = pins_q[2];

  spi_ee_edge #(.RST_VAL(1'b1)) u_cs_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sig_i (cs_q),
    .rise_o(cs_rise),
    .fall_o(cs_fall)
  );

  spi_ee_edge #(.RST_VAL(1'b0)) u_sck_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sig_i (sck_q),
    .rise_o(sck_rise),
    .fall_o(sck_fall)
  );

  spi_ee_ctrl #(
    .ADDR_W (ADDR_W),
    .BP_INIT(BP_INIT)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_q_i     (cs_q),
    .cs_rise_i  (cs_rise),
    .cs_fall_i  (cs_fall),
    .sck_rise_i (sck_rise),
    .sck_fall_i (sck_fall),
    .mosi_i     (mosi_q),
    .wip_i      (wip),
    .wdone_i    (wdone),
    .mem_rdata_i(rdata),
    .mem_raddr_o(raddr),
    .wr_start_o (wr_start),
    .wr_addr_o  (waddr),
    .wr_data_o  (wdata),
    .wel_o      (wel),
    .rd_mem_o   (rd_mem),
    .miso_o     (miso_o),
    .miso_oe_o  (miso_oe_o)
  );

  spi_ee_wtimer #(.CYCLES(WRITE_CYCLES)) u_wtimer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(wr_start),
    .busy_o (wip),
    .done_o (wdone)
  );

  // array is committed at cycle start; reads are locked out until it ends
  spi_ee_mem #(
    .ADDR_W(ADDR_W),
    .DATA_W(8)
  ) u_mem (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (wr_start),
    .waddr_i(waddr),
    .wdata_i(wdata),
    .raddr_i(raddr),
    .rdata_o(rdata)
  );
endmodule

// File: rtl/spi_ee_checker.sv
module spi_ee_checker #(
  parameter int WRITE_CYCLES = 64
) (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_ni,
  input logic miso_oe_o,
  input logic wip_i,
  input logic wel_i,
  input logic cs_rise_i,
  input logic rd_mem_i
);
  logic [31:0] wip_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    wip_cnt_q <= '0;
    else if (wip_i) wip_cnt_q <= wip_cnt_q + 32'd1;
    else            wip_cnt_q <= '0;
  end

  // R5: pad released once deselect has crossed the two-stage synchroniser
  assert_oe_off_deselected_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni && $past(cs_ni) && $past(cs_ni, 2) && $past(cs_ni, 3) |-> !miso_oe_o);

  assert_wel_set_on_deselect_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wel_i) |-> $past(cs_rise_i));

  assert_write_needs_wel_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wip_i) |-> $past(wel_i));

  assert_wel_cleared_at_end_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wip_i) |-> !wel_i);

  assert_wip_length_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wip_i) |-> wip_cnt_q == 32'(WRITE_CYCLES));

  assert_no_read_while_busy_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wip_i |-> !rd_mem_i);
endmodule

bind spi_eeprom_slave spi_ee_checker #(.WRITE_CYCLES(WRITE_CYCLES)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cs_ni    (cs_ni),
  .miso_oe_o(miso_oe_o),
  .wip_i    (wip),
  .wel_i    (wel),
  .cs_rise_i(cs_rise),
  .rd_mem_i (rd_mem)
);

// File: tb/spi_eeprom_slave_tb.sv
module spi_eeprom_slave_tb;
  localparam int WC   = 300;
  localparam int HALF = 4;
  localparam int NVEC = 6;
  // {address, data}
  localparam logic [15:0] VEC [NVEC] = '{16'h00A5, 16'h013C, 16'h7F81,
                                         16'hFE11, 16'hFF22, 16'h40FF};

  logic clk = 1'b0;
  logic rst_ni, cs_ni, sck_i, mosi_i;
  logic miso_o, miso_oe_o;
  int   n_chk = 0;
  int   n_err = 0;
  bit   finished = 1'b0;

  always #2.5 clk = ~clk;

  spi_eeprom_slave #(.WRITE_CYCLES(WC)) u_dut (
    .clk_i    (clk),
    .rst_ni   (rst_ni),
    .cs_ni    (cs_ni),
    .sck_i    (sck_i),
    .mosi_i   (mosi_i),
    .miso_o   (miso_o),
    .miso_oe_o(miso_oe_o)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic spi_bits(input logic [7:0] tx, input int n,
                          output logic [7:0] rx, output logic oe_seen);
    rx = '0;
    oe_seen = 1'b0;
    for (int i = 7; i > 7 - n; i--) begin
      mosi_i = tx[i];
      tick(HALF);
      rx[i]   = miso_o;
      oe_seen = oe_seen | miso_oe_o;
      sck_i = 1'b1;
      tick(HALF);
      sck_i = 1'b0;
    end
  endtask

  task automatic sel();
    cs_ni = 1'b0;
    tick(HALF);
  endtask

  task automatic desel();
    tick(HALF);
    cs_ni = 1'b1;
    tick(8);
  endtask

  task automatic wren();
    logic [7:0] d; logic o;
    sel(); spi_bits(8'h06, 8, d, o); desel();
  endtask

  task automatic write_byte(input logic [7:0] a, input logic [7:0] v, input int extra);
    logic [7:0] d; logic o;
    sel();
    spi_bits(8'h02, 8, d, o);
    spi_bits(a, 8, d, o);
    spi_bits(v, 8, d, o);
    if (extra > 0) spi_bits(8'h00, extra, d, o);
    desel();
  endtask

  task automatic rdsr(output logic [7:0] st);
    logic o;
    sel(); spi_bits(8'h05, 8, st, o); spi_bits(8'h00, 8, st, o); desel();
  endtask

  task automatic read_byte(input logic [7:0] a, output logic [7:0] v, output logic oe);
    logic [7:0] d; logic o;
    sel();
    spi_bits(8'h03, 8, d, o);
    spi_bits(a, 8, d, o);
    spi_bits(8'h00, 8, v, oe);
    desel();
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=done");
    summary();
  end

  initial begin
    logic [7:0] st, st2, v, d;
    logic oe, o;
    rst_ni = 1'b0; cs_ni = 1'b1; sck_i = 1'b0; mosi_i = 1'b0;
    tick(5);
    chk("R1 oe in reset", {7'd0, miso_oe_o}, 8'h00);
    rst_ni = 1'b1;
    tick(5);
    rdsr(st);
    chk("R1 R12 status after reset", st, 8'h00);

    // table walk: write each vector, then read each back
    for (int k = 0; k < NVEC; k++) begin
      wren();
      write_byte(VEC[k][15:8], VEC[k][7:0], 0);
      tick(WC + 20);
    end
    for (int k = 0; k < NVEC; k++) begin
      read_byte(VEC[k][15:8], v, oe);
      chk("R2 R3 R7 read back", v, VEC[k][7:0]);
      chk("R3 oe during read", {7'd0, oe}, 8'h01);
    end

    // R4: sequential read across FFh -> 00h
    sel();
    spi_bits(8'h03, 8, d, o);
    spi_bits(8'hFE, 8, d, o);
    spi_bits(8'h00, 8, v, o); chk("R4 seq FE", v, 8'h11);
    spi_bits(8'h00, 8, v, o); chk("R4 seq FF", v, 8'h22);
    spi_bits(8'h00, 8, v, o); chk("R4 wrap 00", v, 8'hA5);
    spi_bits(8'h00, 8, v, o); chk("R4 wrap 01", v, 8'h3C);
    desel();

    // R5: deselect mid-byte
    sel();
    spi_bits(8'h03, 8, d, o);
    spi_bits(8'h7F, 8, d, o);
    spi_bits(8'h00, 4, v, o);
    chk("R5 partial read bits", v & 8'hF0, 8'h80);
    desel();
    chk("R5 oe after deselect", {7'd0, miso_oe_o}, 8'h00);
    read_byte(8'h7F, v, oe);
    chk("R5 read after abort", v, 8'h81);

    // R6, R12: write enable latch and live status repeat
    wren();
    sel();
    spi_bits(8'h05, 8, d, o);
    spi_bits(8'h00, 8, st, o);
    spi_bits(8'h00, 8, st2, o);
    desel();
    chk("R6 R12 status wel", st, 8'h02);
    chk("R12 status repeat", st2, 8'h02);

    // R7, R10, R11: valid write, busy behaviour
    write_byte(8'h10, 8'h5A, 0);
    rdsr(st);
    chk("R10 R12 status busy", st, 8'h03);
    read_byte(8'h10, v, oe);
    chk("R11 read refused while busy", {7'd0, oe}, 8'h00);
    tick(WC);
    rdsr(st);
    chk("R10 status after cycle", st, 8'h00);
    read_byte(8'h10, v, oe);
    chk("R7 stored byte", v, 8'h5A);

    // R9: write without latch
    write_byte(8'h10, 8'h77, 0);
    rdsr(st);
    chk("R9 no cycle started", st, 8'h00);
    tick(WC);
    read_byte(8'h10, v, oe);
    chk("R9 memory unchanged", v, 8'h5A);

    // R8: extra clock after data byte cancels
    wren();
    write_byte(8'h10, 8'h99, 1);
    rdsr(st);
    chk("R8 cancelled, latch kept", st, 8'h02);
    tick(WC);
    read_byte(8'h10, v, oe);
    chk("R8 memory unchanged", v, 8'h5A);

    // R13: unknown opcode
    sel();
    spi_bits(8'hAB, 8, d, o);
    spi_bits(8'h10, 8, d, oe);
    spi_bits(8'h00, 8, d, o);
    oe = oe | o;
    desel();
    chk("R13 no output on unknown op", {7'd0, oe}, 8'h00);
    rdsr(st);
    chk("R13 status unchanged", st, 8'h02);

    summary();
  end
endmodule